// File: doc/BRIEF.md
# Sync Activity Monitor with Change Interrupt

The block watches the vertical and horizontal sync inputs of two independent sync channels, all sampled on a free-running crystal clock. Each sync input passes through a two-flop synchroniser. Over a long fixed window of crystal cycles the block records whether the input toggled in both directions and how long it sat high. At the end of each window it publishes two flags per input: whether the input is active and what its polarity is.

Each channel compares its four flags with their previous values. Any difference starts a fixed-length raw change pulse and sets a sticky status bit. Software reads the status and clears it by writing ones. Two per-channel mask registers route the status bits to two separate active-high interrupt lines. The register port is a single write strobe with a 2-bit address. Reads come back combinationally from the same address.

Top module: `sync_activity_monitor`

## Requirements
- R1: Each sync input is counted as active for a window of 2^WIN_LOG2 crystal cycles (default WIN_LOG2 = 22) when its synchronised value showed at least one rising and at least one falling edge inside that window.
- R2: The flags on `sync_flags` change only at window boundaries, and they hold their value for the whole of every window. Channel c uses bits [4c+3] VS active, [4c+2] VS polarity, [4c+1] HS active and [4c] HS polarity. All flags reset to 0.
- R3: The polarity flag becomes 1 (positive) when the input was high for fewer than half of the window's cycles, and 0 otherwise. While the input is judged inactive, the polarity flag keeps its previous value.
- R4: The raw change indicator of a channel is 1 for exactly PULSE_LEN (default 15) cycles when any of that channel's four flags changes. It rises one cycle after the flag change and is 0 at all other times.
- R5: A new flag change while the raw indicator is still high reloads the full pulse length, so the indicator stays high without a gap.
- R6: A flag change sets the channel's sticky status bit in the same cycle that the raw indicator rises. If a set and a clear land on the same cycle, the set wins.
- R7: Once set, the status bit holds until a write to address 1 with a 1 in that channel's data bit. A clear takes effect at the clock edge of the write.
- R8: `irq_a` is the OR over channels of status AND mask A. `irq_b` is the OR over channels of status AND mask B. Both are active-high levels.
- R9: The channels are independent. Activity on one channel never changes another channel's flags, raw indicator or status.
- R10: The register map by `reg_addr` is as follows. Address 0 reads the status bits. Address 1 reads the raw indicators and takes the write-1-to-clear. Address 2 reads and writes mask A. Address 3 reads and writes mask B. Bit c of the data belongs to channel c, and both masks reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vs_in | input | NCH | Vertical sync input per channel, asynchronous |
| hs_in | input | NCH | Horizontal sync input per channel, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NCH | Write data, one bit per channel |
| reg_rdata | output | NCH | Read data for `reg_addr`, combinational |
| sync_flags | output | 4*NCH | Published activity and polarity flags |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The bench reduces the window to 8 cycles. Flag values are checked only after several whole windows of steady stimulus, so they are sampled when their position relative to the window phase no longer matters. The raw indicator is checked on falling edges: the bench finds its first high cycle and then counts the consecutive high cycles. It expects 15 cycles for a single change, and 23 when a second change follows exactly one window later. Register writes take effect at the next rising edge. For the set-wins case, the bench places a clear on the edge that is known to be 8 cycles after the raw rise, which is the edge where the second set lands. It reads status and interrupt levels half a cycle after that edge.

// File: rtl/sam_pkg.sv
package sam_pkg;

  typedef struct packed {
    logic vs_act;
    logic vs_pol;
    logic hs_act;
    logic hs_pol;
  } sam_flags_t;

  typedef enum logic [1:0] {
    SAM_RD_STATUS = 2'd0,
    SAM_CLR_RAW   = 2'd1,
    SAM_MASK_A    = 2'd2,
    SAM_MASK_B    = 2'd3
  } sam_addr_e;

endpackage

// File: rtl/sam_window_timer.sv
module sam_window_timer #(
  parameter int WIN_LOG2 = 22
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end_o
);

  logic [WIN_LOG2-1:0] cnt_q;
  logic [WIN_LOG2-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(WIN_LOG2-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign win_end_o = &cnt_q;

endmodule

// File: rtl/sam_sync_judge.sv
module sam_sync_judge #(
  parameter int WIN_LOG2 = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic win_end_i,
  output logic act_o,
  output logic pol_o
);

  localparam int CW = WIN_LOG2 + 1;
  localparam logic [CW-1:0] HALF = CW'(1) << (WIN_LOG2 - 1);

  logic meta_q, s_q, prev_q;
  logic saw_r_q, saw_f_q, act_q, pol_q;
  logic saw_r_d, saw_f_d, act_d, pol_d;
  logic [CW-1:0] hi_q, hi_d, hi_tot;
  logic rise, fall, eval_act, eval_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      s_q    <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= sync_i;
      s_q    <= meta_q;
      prev_q <= s_q;
    end
  end

  assign rise = s_q & ~prev_q;
  assign fall = ~s_q & prev_q;

  always_comb begin
    hi_tot   = hi_q + {{(CW-1){1'b0}}, s_q};
    eval_act = (saw_r_q | rise) & (saw_f_q | fall);
    eval_pos = (hi_tot < HALF);
    saw_r_d  = saw_r_q | rise;
    saw_f_d  = saw_f_q | fall;
    hi_d     = hi_tot;
    act_d    = act_q;
    pol_d    = pol_q;
    if (win_end_i) begin
      saw_r_d = 1'b0;
      saw_f_d = 1'b0;
      hi_d    = '0;
      act_d   = eval_act;
      pol_d   = eval_act ? eval_pos : pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saw_r_q <= 1'b0;
      saw_f_q <= 1'b0;
      hi_q    <= '0;
      act_q   <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      saw_r_q <= saw_r_d;
      saw_f_q <= saw_f_d;
      hi_q    <= hi_d;
      act_q   <= act_d;
      pol_q   <= pol_d;
    end
  end

  assign act_o = act_q;
  assign pol_o = pol_q;

  a_r2_flags_hold_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end_i |=> ($stable(act_o) && $stable(pol_o)));

  a_r3_pol_kept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && !eval_act) |=> $stable(pol_o));

  a_r1_active_needs_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && !saw_r_q && !rise) |=> !act_o);

endmodule

// File: rtl/sam_chan_status.sv
module sam_chan_status #(
  parameter int PULSE_LEN = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] flags_i,
  input  logic       clr_i,
  output logic       raw_o,
  output logic       status_o
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [3:0]    prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          st_q, st_d, chg;

  assign chg = (flags_i != prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (chg)               cnt_d = CW'(PULSE_LEN);
    else if (cnt_q != '0)  cnt_d = cnt_q - {{(CW-1){1'b0}}, 1'b1};
    st_d = st_q;
    if (clr_i) st_d = 1'b0;
    if (chg)   st_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= flags_i;
      cnt_q  <= cnt_d;
      st_q   <= st_d;
    end
  end

  assign raw_o    = (cnt_q != '0);
  assign status_o = st_q;

  a_r4_raw_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_o) |-> $past(chg));

  a_r5_reload_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> raw_o);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> status_o);

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !clr_i) |=> status_o);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !chg) |=> !status_o);

endmodule

// File: rtl/sync_activity_monitor.sv
module sync_activity_monitor #(
  parameter int NCH       = 2,
  parameter int WIN_LOG2  = 22,
  parameter int PULSE_LEN = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   vs_in,
  input  logic [NCH-1:0]   hs_in,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [NCH-1:0]   reg_wdata,
  output logic [NCH-1:0]   reg_rdata,
  output logic [4*NCH-1:0] sync_flags,
  output logic             irq_a,
  output logic             irq_b
);
  import sam_pkg::*;

  logic rs1_q, rs2_q, rst_i_n;
  logic win_end;
  logic [NCH-1:0] raw, status, clr;
  logic [NCH-1:0] mask_a_q, mask_a_d, mask_b_q, mask_b_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  sam_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .win_end_o(win_end)
  );

  assign clr = (reg_we && reg_addr == SAM_CLR_RAW) ? reg_wdata : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sam_flags_t f;

    sam_sync_judge #(.WIN_LOG2(WIN_LOG2)) u_vs (
      .clk(clk), .rst_n(rst_i_n), .sync_i(vs_in[c]), .win_end_i(win_end),
      .act_o(f.vs_act), .pol_o(f.vs_pol)
    );

    sam_sync_judge #(.WIN_LOG2(WIN_LOG2)) u_hs (
      .clk(clk), .rst_n(rst_i_n), .sync_i(hs_in[c]), .win_end_i(win_end),
      .act_o(f.hs_act), .pol_o(f.hs_pol)
    );

    sam_chan_status #(.PULSE_LEN(PULSE_LEN)) u_st (
      .clk(clk), .rst_n(rst_i_n), .flags_i(f), .clr_i(clr[c]),
      .raw_o(raw[c]), .status_o(status[c])
    );

    assign sync_flags[4*c +: 4] = f;
  end

  always_comb begin
    mask_a_d = mask_a_q;
    mask_b_d = mask_b_q;
    if (reg_we && reg_addr == SAM_MASK_A) mask_a_d = reg_wdata;
    if (reg_we && reg_addr == SAM_MASK_B) mask_b_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
    end else begin
      mask_a_q <= mask_a_d;
      mask_b_q <= mask_b_d;
    end
  end

  always_comb begin
    case (reg_addr)
      SAM_RD_STATUS: reg_rdata = status;
      SAM_CLR_RAW:   reg_rdata = raw;
      SAM_MASK_A:    reg_rdata = mask_a_q;
      default:       reg_rdata = mask_b_q;
    endcase
  end

  assign irq_a = |(status & mask_a_q);
  assign irq_b = |(status & mask_b_q);

  a_r8_no_irq_without_mask: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mask_a_q == '0 && mask_b_q == '0) |-> (!irq_a && !irq_b));

  a_r10_mask_a_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_we && reg_addr == SAM_MASK_A) |=> (mask_a_q == $past(reg_wdata)));

endmodule

// File: tb/tb_sync_activity_monitor.sv
module tb_sync_activity_monitor;

  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] vs_in, hs_in;
  logic reg_we;
  logic [1:0] reg_addr;
  logic [NCH-1:0] reg_wdata, reg_rdata;
  logic [4*NCH-1:0] sync_flags;
  logic irq_a, irq_b;

  int n_run = 0;
  int n_fail = 0;

  // stimulus generator: mode 0 low, 1 high, 2 one-high-three-low, 3 three-high-one-low
  int cyc = 0;
  int mode [4];
  int start [4];

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic gen(int m, int ph);
    case (m)
      1: return 1'b1;
      2: return ((ph % 4) == 0);
      3: return ((ph % 4) != 0);
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      vs_in[c] = gen(mode[2*c],   cyc - start[2*c]);
      hs_in[c] = gen(mode[2*c+1], cyc - start[2*c+1]);
    end
  end

  sync_activity_monitor #(.NCH(NCH), .WIN_LOG2(3), .PULSE_LEN(15)) dut (
    .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .hs_in(hs_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sync_flags(sync_flags), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(int idx, int m);
    @(posedge clk); #1;
    mode[idx]  = m;
    start[idx] = cyc;
  endtask

  task automatic rd(logic [1:0] a, output logic [NCH-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [NCH-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  // returns number of consecutive high cycles of raw bit ch, 0 if it never rises
  task automatic raw_len(int ch, output int len);
    len = 0;
    reg_addr = 2'd1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (reg_rdata[ch]) break;
    end
    while (reg_rdata[ch] && len < 300) begin
      len++;
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 4; i++) begin mode[i] = 0; start[i] = 0; end
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [NCH-1:0] d;
    check("R2 flags after reset", sync_flags, 0);
    rd(2'd0, d); check("R10 status after reset", d, 0);
    rd(2'd2, d); check("R10 mask A after reset", d, 0);
    check("R8 irq_a after reset", irq_a, 0);
    repeat (40) @(negedge clk);
    check("R1 quiet inputs stay inactive", sync_flags, 0);
    rd(2'd0, d); check("R4 no change no status", d, 0);
  endtask

  task automatic t_single_pulse();
    int len;
    logic [NCH-1:0] d;
    set_mode(0, 2);
    raw_len(0, len);
    check("R4 raw pulse length", len, 15);
    repeat (20) @(negedge clk);
    check("R1 R3 ch0 vs active positive", sync_flags, 8'b0000_1100);
    rd(2'd0, d); check("R6 status set ch0", d, 2'b01);
    check("R8 irq_a masked off", irq_a, 0);
    check("R8 irq_b masked off", irq_b, 0);
  endtask

  task automatic t_masks_and_clear();
    logic [NCH-1:0] d;
    wr(2'd2, 2'b01);
    check("R8 irq_a with mask", irq_a, 1);
    check("R8 irq_b without mask", irq_b, 0);
    rd(2'd2, d); check("R10 mask A readback", d, 2'b01);
    wr(2'd3, 2'b10);
    check("R8 irq_b other channel mask", irq_b, 0);
    wr(2'd3, 2'b01);
    check("R8 irq_b with mask", irq_b, 1);
    wr(2'd0, 2'b11);
    rd(2'd0, d); check("R7 write to addr 0 does not clear", d, 2'b01);
    wr(2'd1, 2'b10);
    rd(2'd0, d); check("R7 clear of other bit keeps status", d, 2'b01);
    wr(2'd1, 2'b01);
    rd(2'd0, d); check("R7 write one clears", d, 2'b00);
    check("R8 irq_a after clear", irq_a, 0);
    check("R8 irq_b after clear", irq_b, 0);
    repeat (30) @(negedge clk);
    rd(2'd0, d); check("R7 stays clear without change", d, 2'b00);
  endtask

  task automatic t_polarity();
    logic [NCH-1:0] d;
    set_mode(0, 1);
    repeat (40) @(negedge clk);
    check("R3 inactive keeps polarity", sync_flags, 8'b0000_0100);
    rd(2'd0, d); check("R6 status set by going idle", d, 2'b01);
    wr(2'd1, 2'b01);
    set_mode(0, 3);
    repeat (40) @(negedge clk);
    check("R3 mostly-high gives negative", sync_flags, 8'b0000_1000);
    wr(2'd1, 2'b01);
    rd(2'd0, d); check("R7 cleared before channel 1 test", d, 2'b00);
  endtask

  task automatic t_restart();
    int len;
    logic [NCH-1:0] d;
    set_mode(2, 2);
    repeat (7) @(posedge clk);
    set_mode(3, 2);
    raw_len(1, len);
    check("R5 restart stretches pulse", len, 23);
    repeat (20) @(negedge clk);
    check("R9 ch1 flags, ch0 unchanged", sync_flags, 8'b1111_1000);
    rd(2'd0, d); check("R9 only ch1 status", d, 2'b10);
  endtask

  task automatic t_set_wins();
    logic [NCH-1:0] d;
    set_mode(2, 2);
    repeat (7) @(posedge clk);
    set_mode(3, 2);
    reg_addr = 2'd1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (reg_rdata[1]) break;
    end
    check("R4 raw rose", reg_rdata[1], 1);
    repeat (7) @(posedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 2'b10;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(2'd0, d); check("R6 set wins over clear", d, 2'b10);
    wr(2'd1, 2'b10);
    rd(2'd0, d); check("R7 plain clear afterwards", d, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mode[i] = 0; start[i] = 0; end
    rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    fork
      begin
        do_reset();
        t_reset_state();
        t_single_pulse();
        t_masks_and_clear();
        t_polarity();
        t_restart();
        do_reset();
        t_set_wins();
      end
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule